// File: doc/BRIEF.md
# Key Return Debouncer with Change Interrupt

The block watches two key-return lines, here called line A and line B, while a display scanner steps through its eight segment slots. Each slot that carries a key sample presents one bit of each line, so a full pass yields sixteen key states. A closed key reads as 0 and an open key reads as 1. Every one of the sixteen positions has its own filter. A new level reaches the visible key registers only after a run of identical samples of that position, so a bouncing contact never shows up as a change.

Whenever a filtered key bit changes, the block pulls an open-drain interrupt line low. The host releases it by starting a read of the key registers. In self-addressing mode, the two lowest positions of line A give two device-address bits. These bits go straight to the address output without filtering, read back as open keys and never raise the interrupt. A validity flag drops while the display is blinking, because the scan timing then does not give trustworthy key samples.

Top module: `keyscan_latch`

## Requirements
- R1: Bit k of `key_a_q` and `key_b_q` belongs to scan slot k: bit 7 is the decimal-point position, then A, B, C, D, E, F, and bit 0 is the G position. A strobe with `slot_idx`=k samples only bit k of both lines. A 0 sample means closed and a 1 sample means open.
- R2: `key_a_q` and `key_b_q` are filtered independently, and a change on one line leaves the other register unchanged.
- R3: A stored bit takes the sampled level on the DEBOUNCE_SAMPLES-th consecutive strobe of its slot whose sample differs from the stored level. A sample that equals the stored level restarts the count. Strobes of other slots neither advance nor restart the count. Without a strobe, no key bit changes.
- R4: In the cycle after the edge at which any stored key bit changes, `irq_pull_low` is 1.
- R5: A one-cycle `rd_start` sets `irq_pull_low` to 0 from the next cycle. If a key bit changes at the same edge, the interrupt stays asserted.
- R6: While `self_addr_en` is 1, each strobe of slot 0 copies line A into `addr_bits[0]` and each strobe of slot 1 copies line A into `addr_bits[1]`, with no filtering. In this mode `key_a_q[1:0]` read 2'b11 and never raise the interrupt. While `self_addr_en` is 0, `addr_bits` read 2'b00.
- R7: `keys_valid` is 0 in the cycle after any cycle in which `blink_en` is 1, and 1 in the cycle after a cycle in which `blink_en` is 0.
- R8: After a synchronous reset, both key registers read 8'hFF, `irq_pull_low` is 0, `addr_bits` is 2'b00 and `keys_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle strobe: the key lines hold a valid sample for `slot_idx` |
| slot_idx | input | 3 | Segment slot being sampled (0 = G position ... 7 = decimal point) |
| key_a_raw | input | 1 | Sampled level of return line A (1 = open) |
| key_b_raw | input | 1 | Sampled level of return line B (1 = open) |
| self_addr_en | input | 1 | Use line A slots 0 and 1 as address bits |
| blink_en | input | 1 | Display blinking is active |
| rd_start | input | 1 | Pulse: a read of the key registers begins |
| key_a_q | output | 8 | Filtered key states of line A |
| key_b_q | output | 8 | Filtered key states of line B |
| addr_bits | output | 2 | Unfiltered address bits {A1, A0} |
| keys_valid | output | 1 | Key registers are trustworthy (not blinking) |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low, 0 = released |

## Verification
The bench drives a contact that bounces once just before its run completes. A filter that does not restart on a matching sample, or that counts strobes of any slot, would accept that key too early. It also checks that a read start arriving at the same edge as a new change does not drop the interrupt, since a design that gives priority to the clear would lose that event. In self-addressing mode it checks that the address bits follow a single sample, while a held-closed key in those slots neither shows up nor raises the interrupt. Finally it releases a key after the interrupt has been cleared, to confirm that a release is also reported.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int LINES = 2;
  localparam int LINE_A = 0;
  localparam int LINE_B = 1;
  localparam int ADDR_BITS = 2;
  localparam logic KEY_OPEN = 1'b1;
endpackage

// File: rtl/key_bit_filter.sv
module key_bit_filter #(
  parameter int STABLE_N = 16,
  localparam int CW = $clog2(STABLE_N) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic sample_en,
  input  logic sample_val,
  output logic state_q,
  output logic flip
);
  import keyscan_pkg::*;

  logic [CW-1:0] run_cnt;
  logic          differs;

  always_comb begin
    differs = sample_val != state_q;
    flip    = sample_en && !hold && differs && (run_cnt == CW'(STABLE_N - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state_q <= KEY_OPEN;
      run_cnt <= '0;
    end else if (sample_en) begin
      if (!differs) begin
        run_cnt <= '0;
      end else if (flip) begin
        state_q <= sample_val;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/key_irq_ctrl.sv
module key_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic any_flip,
  input  logic rd_start,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (any_flip) irq_q <= 1'b1;
    else if (rd_start) irq_q <= 1'b0;
  end
endmodule

// File: rtl/keyscan_latch.sv
module keyscan_latch #(
  parameter int KEYS_PER_LINE = 8,
  parameter int DEBOUNCE_SAMPLES = 16,
  localparam int IDX_W = $clog2(KEYS_PER_LINE)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_stb,
  input  logic [IDX_W-1:0]         slot_idx,
  input  logic                     key_a_raw,
  input  logic                     key_b_raw,
  input  logic                     self_addr_en,
  input  logic                     blink_en,
  input  logic                     rd_start,
  output logic [KEYS_PER_LINE-1:0] key_a_q,
  output logic [KEYS_PER_LINE-1:0] key_b_q,
  output logic [1:0]               addr_bits,
  output logic                     keys_valid,
  output logic                     irq_pull_low
);
  import keyscan_pkg::*;

  logic [LINES-1:0][KEYS_PER_LINE-1:0] state;
  logic [LINES-1:0][KEYS_PER_LINE-1:0] flips;
  logic [LINES-1:0]                    raw;
  logic [ADDR_BITS-1:0]                addr_q;
  logic                                valid_q;

  assign raw[LINE_A] = key_a_raw;
  assign raw[LINE_B] = key_b_raw;

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    for (genvar k = 0; k < KEYS_PER_LINE; k++) begin : g_key
      logic hold_k;
      if (ln == LINE_A && k < ADDR_BITS) begin : g_addr_slot
        assign hold_k = self_addr_en;
      end else begin : g_plain_slot
        assign hold_k = 1'b0;
      end
      key_bit_filter #(.STABLE_N(DEBOUNCE_SAMPLES)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold_k),
        .sample_en (slot_stb && (slot_idx == IDX_W'(k))),
        .sample_val(raw[ln]),
        .state_q   (state[ln][k]),
        .flip      (flips[ln][k])
      );
    end
  end

  key_irq_ctrl u_irq (
    .clk     (clk),
    .rst     (rst),
    .any_flip(|flips),
    .rd_start(rd_start),
    .irq_q   (irq_pull_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b1;
    end else begin
      valid_q <= !blink_en;
      for (int b = 0; b < ADDR_BITS; b++) begin
        if (self_addr_en && slot_stb && slot_idx == IDX_W'(b)) addr_q[b] <= key_a_raw;
      end
    end
  end

  assign key_a_q    = state[LINE_A];
  assign key_b_q    = state[LINE_B];
  assign addr_bits  = self_addr_en ? addr_q : '0;
  assign keys_valid = valid_q;
endmodule

// File: rtl/keyscan_latch_chk.sv
module keyscan_latch_chk #(
  parameter int KEYS_PER_LINE = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     slot_stb,
  input logic                     self_addr_en,
  input logic                     blink_en,
  input logic                     rd_start,
  input logic [KEYS_PER_LINE-1:0] key_a_q,
  input logic [KEYS_PER_LINE-1:0] key_b_q,
  input logic [1:0]               addr_bits,
  input logic                     keys_valid,
  input logic                     irq_pull_low
);
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (&key_a_q && &key_b_q && !irq_pull_low && keys_valid)); // R8

  AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!slot_stb && !self_addr_en) |=> ($stable(key_a_q) && $stable(key_b_q))); // R3

  AST_CHANGE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ((key_a_q != $past(key_a_q) || key_b_q != $past(key_b_q)) && !$past(self_addr_en))
      |-> irq_pull_low); // R4

  AST_READ_RELEASES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !slot_stb) |=> !irq_pull_low); // R5

  AST_ADDR_SLOTS_OPEN: assert property (@(posedge clk) disable iff (rst)
    self_addr_en |=> (key_a_q[1:0] == 2'b11)); // R6

  AST_ADDR_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    !self_addr_en |-> (addr_bits == 2'b00)); // R6

  AST_BLINK_INVALID: assert property (@(posedge clk) disable iff (rst)
    blink_en |=> !keys_valid); // R7
endmodule

bind keyscan_latch keyscan_latch_chk #(.KEYS_PER_LINE(KEYS_PER_LINE)) u_chk (
  .clk(clk), .rst(rst), .slot_stb(slot_stb), .self_addr_en(self_addr_en),
  .blink_en(blink_en), .rd_start(rd_start), .key_a_q(key_a_q), .key_b_q(key_b_q),
  .addr_bits(addr_bits), .keys_valid(keys_valid), .irq_pull_low(irq_pull_low)
);

// File: tb/sim_keyscan_latch.sv
`timescale 1ns/1ps
module sim_keyscan_latch;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_stb = 1'b0;
  logic [2:0] slot_idx = '0;
  logic       key_a_raw = 1'b1;
  logic       key_b_raw = 1'b1;
  logic       self_addr_en = 1'b0;
  logic       blink_en = 1'b0;
  logic       rd_start = 1'b0;
  logic [7:0] key_a_q, key_b_q;
  logic [1:0] addr_bits;
  logic       keys_valid, irq_pull_low;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyscan_latch #(.KEYS_PER_LINE(8), .DEBOUNCE_SAMPLES(N)) u0 (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .key_a_raw(key_a_raw), .key_b_raw(key_b_raw), .self_addr_en(self_addr_en),
    .blink_en(blink_en), .rd_start(rd_start), .key_a_q(key_a_q), .key_b_q(key_b_q),
    .addr_bits(addr_bits), .keys_valid(keys_valid), .irq_pull_low(irq_pull_low)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input int idx, input logic a, input logic b, input logic rd = 1'b0);
    @(negedge clk);
    slot_stb = 1'b1; slot_idx = 3'(idx); key_a_raw = a; key_b_raw = b; rd_start = rd;
    @(negedge clk);
    slot_stb = 1'b0; rd_start = 1'b0; key_a_raw = 1'b1; key_b_raw = 1'b1;
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 key A", {8'h0, key_a_q}, 16'h00FF);
    check("R8 key B", {8'h0, key_b_q}, 16'h00FF);
    check("R8 irq/addr/valid", {13'h0, irq_pull_low, addr_bits, keys_valid}, 16'h0001);
  endtask

  task automatic t_press_a();
    for (int i = 0; i < N - 1; i++) strobe(3, 1'b0, 1'b1);
    check("R3 not yet", {key_a_q, key_b_q}, 16'hFFFF);
    check("R4 no irq early", {15'h0, irq_pull_low}, 16'h0000);
    strobe(3, 1'b0, 1'b1);
    check("R1 slot3 closed", {key_a_q, key_b_q}, 16'hF7FF);
    check("R4 irq on change", {15'h0, irq_pull_low}, 16'h0001);
  endtask

  task automatic t_read_clear();
    read_pulse();
    check("R5 released", {15'h0, irq_pull_low}, 16'h0000);
    check("R2 A held", {8'h0, key_a_q}, 16'h00F7);
  endtask

  task automatic t_bounce_b();
    for (int i = 0; i < N - 1; i++) begin
      strobe(7, 1'b1, 1'b0);
      strobe(2, 1'b1, 1'b1);
    end
    strobe(7, 1'b1, 1'b1);
    for (int i = 0; i < N - 1; i++) strobe(7, 1'b1, 1'b0);
    check("R3 bounce restarts", {key_a_q, key_b_q}, 16'hF7FF);
    check("R3 no irq on bounce", {15'h0, irq_pull_low}, 16'h0000);
    strobe(7, 1'b1, 1'b0, 1'b1);
    check("R2 B dp closed", {key_a_q, key_b_q}, 16'hF77F);
    check("R5 change beats read", {15'h0, irq_pull_low}, 16'h0001);
    read_pulse();
    check("R5 cleared after", {15'h0, irq_pull_low}, 16'h0000);
  endtask

  task automatic t_self_addr();
    check("R6 addr zero off", {14'h0, addr_bits}, 16'h0000);
    @(negedge clk); self_addr_en = 1'b1;
    strobe(0, 1'b1, 1'b1);
    check("R6 A0 one sample", {14'h0, addr_bits}, 16'h0001);
    strobe(1, 1'b1, 1'b1);
    check("R6 A1 one sample", {14'h0, addr_bits}, 16'h0003);
    for (int i = 0; i < N + 1; i++) strobe(0, 1'b0, 1'b1);
    check("R6 A0 follows", {14'h0, addr_bits}, 16'h0002);
    check("R6 slot0 reads open", {8'h0, key_a_q}, 16'h00F7);
    check("R6 no irq", {15'h0, irq_pull_low}, 16'h0000);
    @(negedge clk); self_addr_en = 1'b0;
    @(negedge clk);
    check("R6 addr zero again", {14'h0, addr_bits}, 16'h0000);
  endtask

  task automatic t_blink();
    @(negedge clk); blink_en = 1'b1;
    @(negedge clk);
    check("R7 invalid blinking", {15'h0, keys_valid}, 16'h0000);
    blink_en = 1'b0;
    @(negedge clk);
    check("R7 valid again", {15'h0, keys_valid}, 16'h0001);
  endtask

  task automatic t_release_a();
    for (int i = 0; i < N; i++) strobe(3, 1'b1, 1'b1);
    check("R3 release", {key_a_q, key_b_q}, 16'hFF7F);
    check("R4 irq on release", {15'h0, irq_pull_low}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_press_a();
    t_read_clear();
    t_bounce_b();
    t_self_addr();
    t_blink();
    t_release_a();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule